// File: doc/BRIEF.md
# Three-Phase Hall Commutation Controller

This block turns the three Hall sensor bits of a brushless motor into drive commands for a three-phase bridge. Each phase gets a two-bit command: pull toward the supply, pull toward ground, hold at the midpoint, or float. For each of the six valid rotor positions, one phase sources, one sinks and one sits at the midpoint. The analog stage behind the block uses the midpoint level to shape the current.

Three modes sit on top of commutation. When the run input is high, every phase is released and the motor coasts. A brake request shorts the motor by pulling every phase to ground together. The same braking is forced when the speed loop runs from an external reference and that reference clock is absent. Hall codes that no valid rotor position can produce float the bridge. The Hall bits are synchronised before use, and the drive word is registered.

Top module: `hall_commutator`

## Requirements
- R1: While `rst_n` is low, and for the first two rising edges after it rises, `phase_drive` is all zeros (every phase floating).
- R2: Each phase uses a two-bit code: 00 float, 01 sink (low side on), 10 source (high side on), 11 midpoint. Phase A uses bits [1:0], phase B uses bits [3:2] and phase C uses bits [5:4].
- R3: With `hall_in[2]`=H1, `hall_in[1]`=H2 and `hall_in[0]`=H3, the six valid codes drive phases A,B,C as follows: 101 gives sink,source,mid. 100 gives sink,mid,source. 110 gives mid,sink,source. 010 gives source,sink,mid. 011 gives source,mid,sink. 001 gives mid,source,sink.
- R4: When `run_n` is 1, every phase floats, whatever the brake, reference and Hall inputs are.
- R5: When `run_n` is 0 and `brake_req` is 1, every phase sinks (word 6'b010101). This takes priority over the Hall decode.
- R6: When `run_n` is 0, `ext_ref_mode` is 1 and `ref_clk_ok` is 0, every phase sinks, even with `brake_req` at 0.
- R7: When `ext_ref_mode` is 0, `ref_clk_ok` has no effect on `phase_drive`.
- R8: When running and not braking, the Hall codes 000 and 111 make every phase float.
- R9: A change on `run_n`, `brake_req`, `ext_ref_mode` or `ref_clk_ok` appears on `phase_drive` after the next rising edge. A change on `hall_in` appears after the third rising edge.
- R10: At most one phase is at the midpoint at any time. A decoded valid Hall code drives exactly one source, one sink and one midpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| hall_in | input | 3 | Raw Hall bits H1,H2,H3 (bit 2 down to bit 0) |
| run_n | input | 1 | Low runs the motor, high stops it (tie high by default) |
| brake_req | input | 1 | Short-circuit brake request |
| ext_ref_mode | input | 1 | Speed loop uses an external reference clock |
| ref_clk_ok | input | 1 | External reference clock is present |
| phase_drive | output | 6 | Per-phase drive codes, phase A in the low bits |

## Verification
Hall decoding and a mode change can reach the output register in the same cycle. This happens because a Hall edge waits two synchroniser stages, while the control inputs go straight to the next-state logic. The bench applies a Hall change and then raises the brake request, or drops the reference clock, exactly two cycles later. Both effects then meet at the same edge. The scoreboard then expects the all-sink word, not the newly decoded pattern. It also expects the new pattern to show up in the cycle after the brake is released.

// File: rtl/hc_pkg.sv
package hc_pkg;

  localparam int unsigned PHASES    = 3;
  localparam int unsigned CODE_W    = 2;
  localparam int unsigned DRIVE_W   = PHASES * CODE_W;
  localparam int unsigned HALL_W    = 3;

  typedef enum logic [CODE_W-1:0] {
    DRV_FLOAT  = 2'b00,
    DRV_SINK   = 2'b01,
    DRV_SOURCE = 2'b10,
    DRV_MID    = 2'b11
  } drv_code_e;

  typedef logic [DRIVE_W-1:0] drive_word_t;

endpackage

// File: rtl/hc_reset_sync.sv
module hc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/hc_hall_sync.sv
module hc_hall_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], raw_in[b]};
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) sh_q <= '0;
      else         sh_q <= sh_d;
    end

    assign sync_out[b] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/hc_decode.sv
module hc_decode
  import hc_pkg::*;
(
  input  logic [HALL_W-1:0] hall,
  output drive_word_t       pattern,
  output logic              valid
);

  always_comb begin
    valid   = 1'b1;
    pattern = '0;
    unique case (hall)
      3'b101:  pattern = {DRV_MID,    DRV_SOURCE, DRV_SINK};
      3'b100:  pattern = {DRV_SOURCE, DRV_MID,    DRV_SINK};
      3'b110:  pattern = {DRV_SOURCE, DRV_SINK,   DRV_MID};
      3'b010:  pattern = {DRV_MID,    DRV_SINK,   DRV_SOURCE};
      3'b011:  pattern = {DRV_SINK,   DRV_MID,    DRV_SOURCE};
      3'b001:  pattern = {DRV_SINK,   DRV_SOURCE, DRV_MID};
      default: begin
        valid   = 1'b0;
        pattern = '0;
      end
    endcase
  end

endmodule

// File: rtl/hc_drive_ctrl.sv
module hc_drive_ctrl
  import hc_pkg::*;
(
  input  logic        clk,
  input  logic        srst_n,
  input  logic        run_n,
  input  logic        brake_req,
  input  logic        ext_ref_mode,
  input  logic        ref_clk_ok,
  input  logic        hall_valid,
  input  drive_word_t hall_pattern,
  output drive_word_t drive_q
);

  drive_word_t all_sink;
  drive_word_t drive_nxt;
  logic        brake_any;
  logic        load_en;
  logic [PHASES-1:0] mid_flag;
  logic [PHASES-1:0] src_flag;
  logic [PHASES-1:0] snk_flag;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    assign all_sink[p*CODE_W +: CODE_W] = DRV_SINK;
    assign mid_flag[p] = (drive_q[p*CODE_W +: CODE_W] == DRV_MID);
    assign src_flag[p] = (drive_q[p*CODE_W +: CODE_W] == DRV_SOURCE);
    assign snk_flag[p] = (drive_q[p*CODE_W +: CODE_W] == DRV_SINK);
  end

  always_comb begin
    brake_any = brake_req | (ext_ref_mode & ~ref_clk_ok);
    if (run_n)            drive_nxt = '0;
    else if (brake_any)   drive_nxt = all_sink;
    else if (!hall_valid) drive_nxt = '0;
    else                  drive_nxt = hall_pattern;
    load_en = (drive_nxt != drive_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      drive_q <= '0;
    else if (load_en) drive_q <= drive_nxt;
  end

  assert_stop_float_R4: assert property (@(posedge clk) disable iff (!srst_n)
    run_n |=> (drive_q == '0));

  assert_brake_sink_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (!run_n && brake_req) |=> (snk_flag == {PHASES{1'b1}}));

  assert_noref_sink_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (!run_n && ext_ref_mode && !ref_clk_ok) |=> (snk_flag == {PHASES{1'b1}}));

  assert_bad_hall_float_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (!run_n && !brake_req && !(ext_ref_mode && !ref_clk_ok) && !hall_valid)
      |=> (drive_q == '0));

  assert_one_mid_R10: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(mid_flag));

  assert_three_level_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (!run_n && !brake_req && !(ext_ref_mode && !ref_clk_ok) && hall_valid)
      |=> ($countones(src_flag) == 1 && $countones(snk_flag) == 1
           && $countones(mid_flag) == 1));

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hc_pkg::*;
#(
  parameter int unsigned HALL_SYNC_STAGES = 2,
  parameter int unsigned RST_SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HALL_W-1:0]    hall_in,
  input  logic                 run_n,
  input  logic                 brake_req,
  input  logic                 ext_ref_mode,
  input  logic                 ref_clk_ok,
  output logic [DRIVE_W-1:0]   phase_drive
);

  logic              srst_n;
  logic [HALL_W-1:0] hall_s;
  drive_word_t       pattern;
  logic              pattern_ok;
  drive_word_t       drive_q;

  hc_reset_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  hc_hall_sync #(.WIDTH(HALL_W), .STAGES(HALL_SYNC_STAGES)) u_sync (
    .clk      (clk),
    .srst_n   (srst_n),
    .raw_in   (hall_in),
    .sync_out (hall_s)
  );

  hc_decode u_dec (
    .hall    (hall_s),
    .pattern (pattern),
    .valid   (pattern_ok)
  );

  hc_drive_ctrl u_ctrl (
    .clk          (clk),
    .srst_n       (srst_n),
    .run_n        (run_n),
    .brake_req    (brake_req),
    .ext_ref_mode (ext_ref_mode),
    .ref_clk_ok   (ref_clk_ok),
    .hall_valid   (pattern_ok),
    .hall_pattern (pattern),
    .drive_q      (drive_q)
  );

  assign phase_drive = drive_q;

endmodule

// File: tb/hall_commutator_test.sv
module hall_commutator_test;

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall_in = 3'b101;
  logic       run_n = 1'b1;
  logic       brake_req = 1'b0;
  logic       ext_ref_mode = 1'b0;
  logic       ref_clk_ok = 1'b0;
  logic [5:0] phase_drive;

  int    n_checks = 0;
  int    n_fails  = 0;
  string tag = "R1";
  item_t sb[$];

  logic [2:0] m1 = 3'b000;
  logic [2:0] m2 = 3'b000;
  int         rel_cnt = 0;

  always #2 clk = ~clk;

  hall_commutator uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hall_in      (hall_in),
    .run_n        (run_n),
    .brake_req    (brake_req),
    .ext_ref_mode (ext_ref_mode),
    .ref_clk_ok   (ref_clk_ok),
    .phase_drive  (phase_drive)
  );

  function automatic logic [5:0] model(input logic rn, input logic brk,
                                       input logic ext, input logic ok,
                                       input logic [2:0] h);
    if (rn) return 6'b000000;
    if (brk || (ext && !ok)) return 6'b010101;
    case (h)
      3'b101: return {2'b11, 2'b10, 2'b01};
      3'b100: return {2'b10, 2'b11, 2'b01};
      3'b110: return {2'b10, 2'b01, 2'b11};
      3'b010: return {2'b11, 2'b01, 2'b10};
      3'b011: return {2'b01, 2'b11, 2'b10};
      3'b001: return {2'b01, 2'b10, 2'b11};
      default: return 6'b000000;
    endcase
  endfunction

  // Predictor: pushes the expected word for each edge
  always @(posedge clk) begin
    item_t it;
    if (rst_n) begin
      if (rel_cnt < 2) begin
        rel_cnt = rel_cnt + 1;
        it.exp = 6'b000000;
        m1 = 3'b000;
        m2 = 3'b000;
      end else begin
        it.exp = model(run_n, brake_req, ext_ref_mode, ref_clk_ok, m2);
        m2 = m1;
        m1 = hall_in;
      end
      it.tag = tag;
      sb.push_back(it);
    end else begin
      rel_cnt = 0;
    end
  end

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_checks++;
      if (phase_drive !== it.exp) begin
        n_fails++;
        $display("FAIL %s: phase_drive=%b expected=%b", it.tag, phase_drive, it.exp);
      end
    end
  end

  task automatic step(input string t, input logic [2:0] h, input logic rn,
                      input logic brk, input logic ext, input logic ok,
                      input int cycles);
    @(negedge clk);
    tag = t; hall_in = h; run_n = rn; brake_req = brk;
    ext_ref_mode = ext; ref_clk_ok = ok;
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #20000;
    n_fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state observed directly while rst_n is low
    repeat (3) begin
      @(negedge clk);
      n_checks++;
      if (phase_drive !== 6'b000000) begin
        n_fails++;
        $display("FAIL R1: phase_drive=%b expected=000000", phase_drive);
      end
    end
    run_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 / R2: full commutation sequence, R9 latency on each edge
    step("R3", 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 5);
    step("R9", 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 5);
    step("R3", 3'b110, 1'b0, 1'b0, 1'b0, 1'b0, 5);
    step("R2", 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 5);
    step("R10", 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 5);
    step("R3", 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 5);
    // reverse direction
    step("R3", 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 4);
    step("R3", 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 4);

    // R8: invalid codes float the bridge
    step("R8", 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 5);
    step("R8", 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 5);
    step("R8", 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 5);

    // R5: brake over a steady pattern, then brake and Hall edge meet
    step("R5", 3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 4);
    step("R9", 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 3);
    step("R5", 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    step("R5", 3'b100, 1'b0, 1'b1, 1'b0, 1'b0, 3);
    step("R5", 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 3);
    step("R5", 3'b111, 1'b0, 1'b1, 1'b0, 1'b0, 5);

    // R6: external reference missing forces braking
    step("R6", 3'b110, 1'b0, 1'b0, 1'b1, 1'b0, 5);
    step("R6", 3'b110, 1'b0, 1'b0, 1'b1, 1'b1, 4);
    step("R6", 3'b010, 1'b0, 1'b0, 1'b1, 1'b1, 2);
    step("R6", 3'b010, 1'b0, 1'b0, 1'b1, 1'b0, 3);

    // R7: reference flag ignored in internal mode
    step("R7", 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 4);
    step("R7", 3'b010, 1'b0, 1'b0, 1'b0, 1'b1, 4);
    step("R7", 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 4);

    // R4: stop overrides braking, missing reference and Hall
    step("R4", 3'b011, 1'b1, 1'b1, 1'b1, 1'b0, 4);
    step("R4", 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 4);
    step("R9", 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 4);

    // R1: reset reasserted mid-run
    @(negedge clk);
    rst_n = 1'b0;
    tag = "R1";
    @(negedge clk);
    n_checks++;
    if (phase_drive !== 6'b000000) begin
      n_fails++;
      $display("FAIL R1: phase_drive=%b expected=000000", phase_drive);
    end
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule